// File: doc/BRIEF.md
# I2C Target Controller with Host-Paced Clock Stretching

This block is a 7-bit-address I2C target that runs on a fast system clock. It passes the bus lines through a short synchronizer and takes clock edges, START and STOP from the synchronized levels. After a START it shifts in an address byte and compares it with an address that the host programs. If the address matches, the block acknowledges it. For a write request it then stores each data byte in a one-entry buffer for the host. For a read request it sends bytes that the host supplies.

On a read, the block stalls the bus by holding SCL low. It does this after the address and after every byte the controller acknowledges. The host refills the buffer and then grants a release, and only then is SCL let go. On receive, a byte that arrives while the buffer still holds an unread byte is refused with no acknowledge, and an overflow flag is raised. A sticky per-byte flag tells the host that a byte has finished. The bus outputs are pull-low enables for open-drain pads.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset, both pull-low outputs and buf_full_o, ovf_o, irq_o and rd_mode_o are 0.
- R2: A START (SDA falling while SCL is high) restarts address reception even in the middle of a byte. After a STOP (SDA rising while SCL is high) the block ignores bus bits until the next START, and rd_mode_o is cleared.
- R3: For an address byte {addr[6:0], rw} whose addr equals own_addr_i, SDA is pulled low during the ninth clock. For any other addr there is no acknowledge, and the rest of the transfer is ignored.
- R4: On a matching address with rw=1, rd_mode_o goes to 1 and buf_rdata_o takes the address byte {addr, 1'b1}.
- R5: After the ninth clock of a matching read address, SCL is held low. A pulse on rel_set_i has no effect until the buffer has been written through buf_we_i. A write followed by rel_set_i releases SCL.
- R6: Transmit data goes out MSB first. SDA changes only on a falling edge of SCL, so it is stable while SCL is high.
- R7: In transmit, the controller's acknowledge is taken on the ninth rising edge. Low (ACK) makes the block hold SCL low again. High (NACK) leaves SCL released, and the block drives nothing until the next START.
- R8: irq_o is set on the ninth falling edge of every byte of an addressed transfer. It stays set until irq_clr_i is pulsed.
- R9: A received data byte is placed in buf_rdata_o, buf_full_o is set, and the byte is acknowledged. A pulse on buf_re_i clears buf_full_o.
- R10: A data byte that completes while buf_full_o is 1 is not acknowledged. It sets ovf_o and leaves buf_rdata_o unchanged. ovf_clr_i clears ovf_o.
- R11: The release grant is consumed whenever a hold begins. Each hold therefore needs a new buffer write and a new rel_set_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 7 | Programmed target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| buf_wdata_i | input | 8 | Transmit byte from host |
| buf_we_i | input | 1 | Host write strobe for the buffer |
| buf_re_i | input | 1 | Host read strobe, clears buf_full_o |
| buf_rdata_o | output | 8 | Buffer contents |
| rel_set_i | input | 1 | Host request to release SCL |
| irq_clr_i | input | 1 | Clears irq_o |
| ovf_clr_i | input | 1 | Clears ovf_o |
| buf_full_o | output | 1 | Received byte waiting |
| ovf_o | output | 1 | Receive overrun |
| rd_mode_o | output | 1 | Current transfer is a read |
| irq_o | output | 1 | Sticky per-byte flag |

## Verification
A change on the bus pins reaches the controller through two synchronizer flops and one edge-detect flop. The state and SDA/SCL pull outputs then change on the edge after that, and the host flags change one cycle later still. So every bus-driven result is due within five system cycles of a line transition. The bench keeps each quarter of an SCL period eight cycles long. It samples acknowledges and data in the middle of the high phase, and it checks the flags one quarter period after SCL falls, well past that latency. Host strobes act on the next edge. Strobe results are read at least one full cycle later, on a falling clock edge, and "no effect" cases are checked again twenty cycles after the strobe.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX,
    ST_HOLD
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, lvl, lvl_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '1;
    else         lvl_q <= lvl;
  end

  assign scl_o      = lvl[1];
  assign sda_o      = lvl[0];
  assign scl_rise_o = lvl[1] & ~lvl_q[1];
  assign scl_fall_o = ~lvl[1] & lvl_q[1];
  // bus conditions: SDA moves while SCL stays high
  assign start_o    = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
  assign stop_o     = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              buf_full_i,
  input  logic              rel_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic              rd_mode_o,
  output logic              take_o,
  output logic              ev_rx_load_o,
  output logic              ev_addr_copy_o,
  output logic              ev_byte_end_o,
  output logic              ev_ovf_o,
  output logic              ev_hold_o,
  output logic [DATA_W-1:0] shift_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] NINTH = CNT_W'(DATA_W + 1);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q, tx_q;
  logic              ack_q, rd_q, mack_q, tx_done_q;

  assign take_o = (state_q == ST_HOLD) && rel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      cnt_q          <= '0;
      sr_q           <= '0;
      tx_q           <= '0;
      ack_q          <= 1'b0;
      rd_q           <= 1'b0;
      mack_q         <= 1'b0;
      tx_done_q      <= 1'b0;
      ev_rx_load_o   <= 1'b0;
      ev_addr_copy_o <= 1'b0;
      ev_byte_end_o  <= 1'b0;
      ev_ovf_o       <= 1'b0;
      ev_hold_o      <= 1'b0;
    end else begin
      ev_rx_load_o   <= 1'b0;
      ev_addr_copy_o <= 1'b0;
      ev_byte_end_o  <= 1'b0;
      ev_ovf_o       <= 1'b0;
      ev_hold_o      <= 1'b0;
      if (tx_we_i && state_q != ST_TX) tx_q <= tx_data_i;
      if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
        rd_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
        rd_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: ;
          ST_HOLD: begin
            if (rel_i) begin
              state_q   <= ST_TX;
              cnt_q     <= '0;
              tx_done_q <= 1'b0;
            end
          end
          default: begin
            if (scl_rise_i && cnt_q <= LAST) begin
              if (cnt_q < LAST) sr_q <= {sr_q[DATA_W-2:0], sda_s_i};
              else              mack_q <= ~sda_s_i;
              cnt_q <= cnt_q + 1'b1;
            end
            if (scl_fall_i) begin
              if (cnt_q == LAST) begin
                tx_done_q <= 1'b1;
                case (state_q)
                  ST_ADDR: begin
                    if (sr_q[DATA_W-1 -: ADDR_W] == own_addr_i) begin
                      ack_q <= 1'b1;
                      if (sr_q[0]) begin
                        rd_q           <= 1'b1;
                        ev_addr_copy_o <= 1'b1;
                      end
                    end else begin
                      state_q <= ST_IDLE;
                    end
                  end
                  ST_RX: begin
                    if (buf_full_i) ev_ovf_o <= 1'b1;
                    else begin
                      ack_q        <= 1'b1;
                      ev_rx_load_o <= 1'b1;
                    end
                  end
                  default: ;
                endcase
              end else if (cnt_q == NINTH) begin
                ack_q         <= 1'b0;
                cnt_q         <= '0;
                ev_byte_end_o <= 1'b1;
                case (state_q)
                  ST_ADDR: begin
                    if (rd_q) begin
                      state_q   <= ST_HOLD;
                      ev_hold_o <= 1'b1;
                    end else begin
                      state_q <= ST_RX;
                    end
                  end
                  ST_TX: begin
                    if (mack_q) begin
                      state_q   <= ST_HOLD;
                      ev_hold_o <= 1'b1;
                    end else begin
                      state_q <= ST_IDLE;
                      rd_q    <= 1'b0;
                    end
                  end
                  default: ;
                endcase
              end else if (state_q == ST_TX && cnt_q != '0) begin
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
              end
            end
          end
        endcase
      end
    end
  end

  assign scl_pull_o = (state_q == ST_HOLD);
  assign sda_pull_o = ack_q | ((state_q == ST_TX) && !tx_done_q && !tx_q[DATA_W-1]);
  assign rd_mode_o  = rd_q;
  assign shift_o    = sr_q;

  // R5: a hold persists until the host grants release
  p_hold_until_rel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !rel_i && !start_i && !stop_i) |=> scl_pull_o);

  // R6: transmitted bit is steady through the SCL high phase
  p_tx_sda_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && scl_s_i && !scl_rise_i) |-> $stable(sda_pull_o));
endmodule

// File: rtl/i2c_tgt_hostif.sv
module i2c_tgt_hostif #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_we_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_re_i,
  input  logic              rel_set_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  input  logic              hold_i,
  input  logic              take_i,
  input  logic              ev_rx_load_i,
  input  logic              ev_addr_copy_i,
  input  logic              ev_byte_end_i,
  input  logic              ev_ovf_i,
  input  logic              ev_hold_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              rel_o
);
  logic loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o      <= '0;
      buf_full_o <= 1'b0;
      ovf_o      <= 1'b0;
      irq_o      <= 1'b0;
      rel_o      <= 1'b0;
      loaded_q   <= 1'b0;
    end else begin
      if (ev_rx_load_i || ev_addr_copy_i) buf_o <= rx_data_i;
      else if (buf_we_i)                  buf_o <= buf_wdata_i;

      if (ev_rx_load_i)  buf_full_o <= 1'b1;
      else if (buf_re_i) buf_full_o <= 1'b0;

      if (ev_ovf_i)       ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;

      if (ev_byte_end_i)  irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;

      // each hold needs a fresh write, then a fresh release
      if (ev_hold_i || take_i) loaded_q <= 1'b0;
      else if (buf_we_i)       loaded_q <= 1'b1;

      if (take_i)                                rel_o <= 1'b0;
      else if (rel_set_i && loaded_q && hold_i)  rel_o <= 1'b1;
    end
  end

  p_rel_after_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_o) |-> $past(loaded_q));

  p_full_clr_on_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_re_i && !ev_rx_load_i) |=> !buf_full_o);

  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_we_i,
  input  logic              buf_re_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  input  logic              rel_set_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              rd_mode_o,
  output logic              irq_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic rel, take;
  logic ev_rx_load, ev_addr_copy, ev_byte_end, ev_ovf, ev_hold;
  logic [DATA_W-1:0] shift;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_tgt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .own_addr_i     (own_addr_i),
    .scl_s_i        (scl_s),
    .sda_s_i        (sda_s),
    .scl_rise_i     (scl_rise),
    .scl_fall_i     (scl_fall),
    .start_i        (start_c),
    .stop_i         (stop_c),
    .buf_full_i     (buf_full_o),
    .rel_i          (rel),
    .tx_we_i        (buf_we_i),
    .tx_data_i      (buf_wdata_i),
    .scl_pull_o     (scl_pull_o),
    .sda_pull_o     (sda_pull_o),
    .rd_mode_o      (rd_mode_o),
    .take_o         (take),
    .ev_rx_load_o   (ev_rx_load),
    .ev_addr_copy_o (ev_addr_copy),
    .ev_byte_end_o  (ev_byte_end),
    .ev_ovf_o       (ev_ovf),
    .ev_hold_o      (ev_hold),
    .shift_o        (shift)
  );

  i2c_tgt_hostif #(.DATA_W(DATA_W)) u_host (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .buf_we_i       (buf_we_i),
    .buf_wdata_i    (buf_wdata_i),
    .buf_re_i       (buf_re_i),
    .rel_set_i      (rel_set_i),
    .irq_clr_i      (irq_clr_i),
    .ovf_clr_i      (ovf_clr_i),
    .hold_i         (scl_pull_o),
    .take_i         (take),
    .ev_rx_load_i   (ev_rx_load),
    .ev_addr_copy_i (ev_addr_copy),
    .ev_byte_end_i  (ev_byte_end),
    .ev_ovf_i       (ev_ovf),
    .ev_hold_i      (ev_hold),
    .rx_data_i      (shift),
    .buf_o          (buf_rdata_o),
    .buf_full_o     (buf_full_o),
    .ovf_o          (ovf_o),
    .irq_o          (irq_o),
    .rel_o          (rel)
  );

  // R10: the cycle the overrun is flagged, the byte is not being acknowledged
  p_ovf_no_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> !sda_pull_o);
endmodule

// File: tb/i2c_stretch_target_bench.sv
module i2c_stretch_target_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam logic [6:0] OWN = 7'h5A;

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] data;
    logic       ack;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{7'h5A, 8'h3C, 1'b1},
    '{7'h5B, 8'h11, 1'b0},
    '{7'h5A, 8'hFF, 1'b1},
    '{7'h1A, 8'h00, 1'b0},
    '{7'h5A, 8'h00, 1'b1},
    '{7'h2D, 8'h96, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  logic [7:0] wdata = '0, rdata;
  logic we = 0, re = 0, rel_set = 0, irq_clr = 0, ovf_clr = 0;
  logic full, ovf, rd_mode, irq;
  wire scl_line = scl_m & ~scl_pull;
  wire sda_line = sda_m & ~sda_pull;
  int n_cmp = 0, n_err = 0, n_glitch = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_stretch_target u_i2c_stretch_target (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(OWN),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .buf_wdata_i(wdata), .buf_we_i(we), .buf_re_i(re), .buf_rdata_o(rdata),
    .rel_set_i(rel_set), .irq_clr_i(irq_clr), .ovf_clr_i(ovf_clr),
    .buf_full_o(full), .ovf_o(ovf), .rd_mode_o(rd_mode), .irq_o(irq)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  task automatic bus_bit(input logic b, output logic s);
    logic s_early;
    sda_m = b;
    wq(Q);
    scl_m = 1'b1;
    wq(1);
    while (!scl_line) wq(1);
    s_early = sda_line;
    wq(Q);
    s = sda_line;
    if (s != s_early) n_glitch++;
    wq(Q);
    scl_m = 1'b0;
    wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~mack, s);
  endtask

  task automatic start_c();
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; wq(1); sig = 1'b0; wq(1);
  endtask

  task automatic host_write(input logic [7:0] d);
    wdata = d; we = 1'b1; wq(1); we = 1'b0; wq(1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic a;
    logic [7:0] d;
    wq(3);
    // R1 reset state
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 flags", {full, ovf, irq, rd_mode}, 4'h0);
    rst_n = 1'b1;
    wq(4);

    // table of write transfers: R3, R8, R9
    foreach (VEC[k]) begin
      start_c();
      send_byte({VEC[k].addr, 1'b0}, a);
      chk("R3 address ack", a, VEC[k].ack);
      send_byte(VEC[k].data, a);
      chk("R9 data ack", a, VEC[k].ack);
      chk("R8 irq after byte", irq, VEC[k].ack);
      pulse(irq_clr);
      chk("R8 irq cleared", irq, 0);
      stop_c();
      chk("R9 buf_full", full, VEC[k].ack);
      if (VEC[k].ack) chk("R9 buffer data", rdata, VEC[k].data);
      pulse(re);
      chk("R9 full cleared by read", full, 0);
    end

    // R2 START mid-byte restarts address reception
    start_c();
    bus_bit(1'b0, a); bus_bit(1'b1, a); bus_bit(1'b0, a);
    sda_m = 1'b1; wq(Q);
    start_c();
    send_byte({OWN, 1'b0}, a);
    chk("R2 restart address ack", a, 1);
    send_byte(8'h77, a);
    chk("R2 data ack after restart", a, 1);
    stop_c();
    chk("R2 data after restart", rdata, 8'h77);
    pulse(re);
    pulse(irq_clr);
    // R2 bits after STOP ignored
    send_byte(8'hB4, a);
    chk("R2 no ack after stop", a, 0);
    chk("R2 buffer untouched after stop", {full, rdata}, {1'b0, 8'h77});

    // R10 overrun
    start_c();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h81, a);
    chk("R10 first byte ack", a, 1);
    send_byte(8'h42, a);
    chk("R10 overrun nack", a, 0);
    chk("R10 ovf set", ovf, 1);
    chk("R10 buffer kept", rdata, 8'h81);
    stop_c();
    pulse(ovf_clr);
    chk("R10 ovf cleared", ovf, 0);
    pulse(re);
    pulse(irq_clr);

    // read transfer: R4, R5, R6, R7, R11
    start_c();
    send_byte({OWN, 1'b1}, a);
    chk("R4 read address ack", a, 1);
    chk("R4 rd_mode", rd_mode, 1);
    chk("R4 address copied", rdata, {OWN, 1'b1});
    chk("R8 irq after read address", irq, 1);
    pulse(irq_clr);
    chk("R5 scl held", scl_pull, 1);
    pulse(rel_set);
    wq(20);
    chk("R5 release ignored before write", scl_pull, 1);
    host_write(8'hA5);
    wq(4);
    chk("R5 write alone keeps hold", scl_pull, 1);
    pulse(rel_set);
    wq(4);
    chk("R5 released after write and set", scl_pull, 0);
    n_glitch = 0;
    recv_byte(1'b1, d);
    chk("R6 tx byte MSB first", d, 8'hA5);
    chk("R6 sda steady while scl high", n_glitch, 0);
    chk("R8 irq after tx byte", irq, 1);
    chk("R7 hold after ack", scl_pull, 1);
    pulse(irq_clr);
    pulse(rel_set);
    wq(20);
    chk("R11 old grant not reused", scl_pull, 1);
    host_write(8'h3C);
    pulse(rel_set);
    wq(4);
    chk("R11 fresh grant releases", scl_pull, 0);
    recv_byte(1'b0, d);
    chk("R6 second tx byte", d, 8'h3C);
    chk("R7 no hold after nack", scl_pull, 0);
    bus_bit(1'b1, a);
    chk("R7 idle after nack", a, 1);
    stop_c();
    chk("R2 rd_mode cleared by stop", rd_mode, 0);

    summary();
  end
endmodule